// File: doc/BRIEF.md
# Barrel Shifter with Condition Flags

This block is the shift stage of an integer execution pipeline. Each cycle it can accept one operation: a destination operand, a raw shift count, a shift kind and the current condition flags. One clock later it presents the shifted value and the new carry, overflow, sign, zero, parity and adjust flags. It also presents a per-flag write mask, so the flag register outside can merge the new flags with the old ones.

The operand width is chosen per operation: 8, 16, 32 or 64 bits. The raw count is first reduced by a mask that depends on that width. When the reduced count is zero, the operation leaves both the value and every flag as they were. Overflow follows a separate rule for single-bit shifts. The architecture leaves some flag values undefined, and for those the block drives fixed values, so that its output is deterministic.

Top module: `shift_flag_unit`

## Requirements
- R1: The effective count is the low 5 bits of `in_count` for widths 8, 16 and 32, and the low 6 bits for width 64. Width code on `in_size`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R2: Op codes 0 and 1 (two names for the left shift) give the same result. Each step moves the bits toward the MSB and brings a zero in at bit 0.
- R3: Op code 2 (logical right shift) brings zeros in at the top of the selected width.
- R4: Op code 3 (arithmetic right shift) copies the operand's sign bit into the vacated upper positions, so the result rounds toward minus infinity. For example, 8-bit 0xF7 (-9) shifted by 2 gives 0xFD (-3) with carry 1.
- R5: Carry is the last bit shifted out. For op codes 0, 1 and 2 with an effective count greater than or equal to the width, carry is 0.
- R6: With an effective count of 0, the result is the width-truncated operand, `out_flags` equals `in_flags` and `out_flag_mod` is 0.
- R7: With an effective count of 1, overflow is set as follows. For left shifts it is the result MSB XOR the new carry. For the arithmetic right shift it is 0. For the logical right shift it is the MSB of the original operand.
- R8: With an effective count greater than 1, overflow is 0.
- R9: For a nonzero effective count, all six mask bits are 1. Sign is the result MSB at the width. Zero is set when the truncated result is 0. Parity is set when the low 8 result bits hold an even number of ones. Adjust is 0. Flag bit order: 0 carry, 1 parity, 2 adjust, 3 zero, 4 sign, 5 overflow.
- R10: Result bits above the selected width are 0, and operand bits above it have no effect.
- R11: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. The outputs belong to that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Shift kind (0 left, 1 left, 2 logical right, 3 arithmetic right) |
| in_size | input | 2 | Operand width code |
| in_operand | input | 64 | Destination operand |
| in_count | input | CNT_W | Raw shift count |
| in_flags | input | 6 | Incoming flags |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | Shifted value, zero above the width |
| out_flags | output | 6 | New flags |
| out_flag_mod | output | 6 | Mask of the flags written |

## Verification
The bench sweeps every op and width over raw counts 0 to 63. Counts 32 and above fold to smaller values on the narrow widths, so a design that skipped the width-dependent mask would clear the result instead of shifting. Zero counts are sent with varied incoming flags: a unit that still wrote the flags would overwrite them with fresh carry and parity values. Counts equal to the width and beyond catch a carry taken from a stale bit. Counts of 1 on sign-bit patterns expose any mix-up between the three overflow rules. A narrow arithmetic shift that filled from bit 63 instead of the width's sign bit would leave zeros where sign copies belong.

// File: rtl/shu_pkg.sv
package shu_pkg;

  localparam int XLEN  = 64;
  localparam int SH_W  = 6;
  localparam int FLG_N = 6;

  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SAL = 2'd1,
    OP_SHR = 2'd2,
    OP_SAR = 2'd3
  } shift_op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } op_size_e;

  function automatic logic [XLEN-1:0] width_mask(input op_size_e sz);
    case (sz)
      SZ_8:    width_mask = {{(XLEN-8){1'b0}}, 8'hFF};
      SZ_16:   width_mask = {{(XLEN-16){1'b0}}, 16'hFFFF};
      SZ_32:   width_mask = {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};
      default: width_mask = {XLEN{1'b1}};
    endcase
  endfunction

  function automatic logic top_bit(input logic [XLEN-1:0] v, input op_size_e sz);
    case (sz)
      SZ_8:    top_bit = v[7];
      SZ_16:   top_bit = v[15];
      SZ_32:   top_bit = v[31];
      default: top_bit = v[XLEN-1];
    endcase
  endfunction

  function automatic logic [SH_W:0] width_bits(input op_size_e sz);
    case (sz)
      SZ_8:    width_bits = (SH_W+1)'(8);
      SZ_16:   width_bits = (SH_W+1)'(16);
      SZ_32:   width_bits = (SH_W+1)'(32);
      default: width_bits = (SH_W+1)'(XLEN);
    endcase
  endfunction

endpackage

// File: rtl/shu_count_mask.sv
module shu_count_mask
  import shu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  op_size_e         size,
  input  logic [CNT_W-1:0] count,
  output logic [SH_W-1:0]  cnt_eff
);
  logic [SH_W-1:0] limit;

  always_comb begin
    limit   = (size == SZ_64) ? {SH_W{1'b1}} : {1'b0, {(SH_W-1){1'b1}}};
    cnt_eff = count[SH_W-1:0] & limit;
  end
endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
  import shu_pkg::*;
(
  input  shift_op_e       op,
  input  op_size_e        size,
  input  logic [XLEN-1:0] operand,
  input  logic [SH_W-1:0] cnt,
  output logic [XLEN-1:0] result,
  output logic            carry
);
  logic [XLEN-1:0]   msk;
  logic [XLEN-1:0]   opnd_z;
  logic [XLEN-1:0]   sext;
  logic [XLEN-1:0]   raw;
  logic [2*XLEN-1:0] wide_l;
  logic [SH_W-1:0]   last_idx;

  always_comb begin
    msk      = width_mask(size);
    opnd_z   = operand & msk;
    sext     = top_bit(opnd_z, size) ? (opnd_z | ~msk) : opnd_z;
    wide_l   = {{XLEN{1'b0}}, opnd_z} << cnt;
    last_idx = cnt - 1'b1;
    raw      = opnd_z;
    carry    = 1'b0;
    case (op)
      OP_SHL, OP_SAL: begin
        raw = wide_l[XLEN-1:0];
        case (size)
          SZ_8:    carry = wide_l[8];
          SZ_16:   carry = wide_l[16];
          SZ_32:   carry = wide_l[32];
          default: carry = wide_l[XLEN];
        endcase
      end
      OP_SHR: begin
        raw   = opnd_z >> cnt;
        carry = opnd_z[last_idx];
      end
      default: begin
        raw   = XLEN'($signed(sext) >>> cnt);
        carry = sext[last_idx];
      end
    endcase
    result = raw & msk;
  end
endmodule

// File: rtl/shu_flag_gen.sv
module shu_flag_gen
  import shu_pkg::*;
(
  input  shift_op_e        op,
  input  op_size_e         size,
  input  logic [XLEN-1:0]  operand,
  input  logic [XLEN-1:0]  result,
  input  logic             carry,
  input  logic [SH_W-1:0]  cnt,
  input  logic [FLG_N-1:0] flags_in,
  output logic [FLG_N-1:0] flags_out,
  output logic [FLG_N-1:0] flag_mod
);
  logic is_left;
  logic res_msb;
  logic cf_new;

  always_comb begin
    is_left   = (op == OP_SHL) || (op == OP_SAL);
    res_msb   = top_bit(result, size);
    cf_new    = carry;
    flags_out = flags_in;
    flag_mod  = '0;
    if (cnt != '0) begin
      if ((op != OP_SAR) && ({1'b0, cnt} >= width_bits(size))) begin
        cf_new = 1'b0;
      end
      flag_mod        = '1;
      flags_out[F_CF] = cf_new;
      flags_out[F_PF] = ~^result[7:0];
      flags_out[F_AF] = 1'b0;
      flags_out[F_ZF] = (result == '0);
      flags_out[F_SF] = res_msb;
      flags_out[F_OF] = 1'b0;
      if (cnt == SH_W'(1)) begin
        if (is_left) begin
          flags_out[F_OF] = res_msb ^ cf_new;
        end else if (op == OP_SHR) begin
          flags_out[F_OF] = top_bit(operand, size);
        end
      end
    end
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [1:0]       in_size,
  input  logic [63:0]      in_operand,
  input  logic [CNT_W-1:0] in_count,
  input  logic [5:0]       in_flags,
  output logic             out_valid,
  output logic [63:0]      out_result,
  output logic [5:0]       out_flags,
  output logic [5:0]       out_flag_mod
);
  shift_op_e        op_c;
  op_size_e         size_c;
  logic [SH_W-1:0]  cnt_eff;
  logic [XLEN-1:0]  res_nxt;
  logic             carry_nxt;
  logic [FLG_N-1:0] flags_nxt;
  logic [FLG_N-1:0] mod_nxt;
  logic             valid_nxt;

  assign op_c   = shift_op_e'(in_op);
  assign size_c = op_size_e'(in_size);

  shu_count_mask #(.CNT_W(CNT_W)) u_mask (
    .size    (size_c),
    .count   (in_count),
    .cnt_eff (cnt_eff)
  );

  shu_barrel u_barrel (
    .op      (op_c),
    .size    (size_c),
    .operand (in_operand),
    .cnt     (cnt_eff),
    .result  (res_nxt),
    .carry   (carry_nxt)
  );

  shu_flag_gen u_flags (
    .op        (op_c),
    .size      (size_c),
    .operand   (in_operand),
    .result    (res_nxt),
    .carry     (carry_nxt),
    .cnt       (cnt_eff),
    .flags_in  (in_flags),
    .flags_out (flags_nxt),
    .flag_mod  (mod_nxt)
  );

  assign valid_nxt = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_result   <= res_nxt;
      out_flags    <= flags_nxt;
      out_flag_mod <= mod_nxt;
    end
  end
endmodule

// File: rtl/shu_checker.sv
module shu_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_op,
  input logic [1:0]       in_size,
  input logic [CNT_W-1:0] in_count,
  input logic [5:0]       in_flags,
  input logic             out_valid,
  input logic [63:0]      out_result,
  input logic [5:0]       out_flags,
  input logic [5:0]       out_flag_mod
);
  logic [5:0] eff;
  assign eff = in_count[5:0] & ((in_size == 2'd3) ? 6'h3F : 6'h1F);

  // R11
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R6
  a_r6_zero_count_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff == 6'd0) |=> (out_flag_mod == 6'd0 && out_flags == $past(in_flags)));
  // R7
  a_r7_sar_single_of_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd3 && eff == 6'd1) |=> !out_flags[5]);
  // R8
  a_r8_multi_of_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff > 6'd1) |=> !out_flags[5]);
  // R9
  a_r9_parity_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_mod[1]) |-> (out_flags[1] == ~^out_result[7:0]));
  a_r9_adjust_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff != 6'd0) |=> (!out_flags[2] && out_flag_mod == 6'h3F));
  // R10
  a_r10_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0) |=> (out_result[63:8] == 56'd0));
endmodule

bind shift_flag_unit shu_checker #(.CNT_W(CNT_W)) u_shu_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_op        (in_op),
  .in_size      (in_size),
  .in_count     (in_count),
  .in_flags     (in_flags),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_flags    (out_flags),
  .out_flag_mod (out_flag_mod)
);

// File: tb/test_shift_flag_unit.sv
`timescale 1ns/1ps
module test_shift_flag_unit;
  localparam int CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [1:0]       in_op;
  logic [1:0]       in_size;
  logic [63:0]      in_operand;
  logic [CNT_W-1:0] in_count;
  logic [5:0]       in_flags;
  logic             out_valid;
  logic [63:0]      out_result;
  logic [5:0]       out_flags;
  logic [5:0]       out_flag_mod;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [63:0] res;
    logic [5:0]  fl;
    logic [5:0]  fm;
    logic [31:0] tag;
  } exp_t;
  exp_t sbq[$];

  shift_flag_unit #(.CNT_W(CNT_W)) i_shift_flag_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .in_size      (in_size),
    .in_operand   (in_operand),
    .in_count     (in_count),
    .in_flags     (in_flags),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_flags    (out_flags),
    .out_flag_mod (out_flag_mod)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // One bit per step reference, built from the requirements.
  task automatic model(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] opnd,
                       input logic [7:0] cnt, input logic [5:0] fin,
                       output logic [63:0] res, output logic [5:0] fo, output logic [5:0] fm);
    int w;
    int mc;
    logic [63:0] m;
    logic [63:0] v;
    logic cf, osign, of;
    w  = 8 << sz;
    mc = int'(cnt) & ((sz == 2'd3) ? 63 : 31);
    m  = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    v  = opnd & m;
    osign = v[w-1];
    cf = 1'b0;
    for (int i = 0; i < mc; i++) begin
      if (op < 2'd2) begin
        cf = v[w-1];
        v  = (v << 1) & m;
      end else if (op == 2'd2) begin
        cf = v[0];
        v  = v >> 1;
      end else begin
        cf = v[0];
        v  = (v >> 1) | ({63'd0, osign} << (w-1));
      end
    end
    res = v;
    if (mc == 0) begin
      fo = fin;
      fm = 6'd0;
    end else begin
      if (op != 2'd3 && mc >= w) cf = 1'b0;
      of = 1'b0;
      if (mc == 1) begin
        if (op < 2'd2) of = v[w-1] ^ cf;
        else if (op == 2'd2) of = osign;
      end
      fo = {of, v[w-1], (v == 64'd0), 1'b0, ~^v[7:0], cf};
      fm = 6'h3F;
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] opnd,
                      input logic [7:0] cnt, input logic [5:0] fin, input logic [31:0] tag);
    exp_t e;
    model(op, sz, opnd, cnt, fin, e.res, e.fl, e.fm);
    e.tag = tag;
    @(negedge clk);
    in_valid   = 1'b1;
    in_op      = op;
    in_size    = sz;
    in_operand = opnd;
    in_count   = cnt;
    in_flags   = fin;
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input logic [31:0] tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_valid=%b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected result %h, expected no output", out_result);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (out_result !== e.res || out_flags !== e.fl || out_flag_mod !== e.fm) begin
          errors++;
          $display("FAIL %s: res=%h flags=%b mod=%b expected res=%h flags=%b mod=%b",
                   e.tag, out_result, out_flags, out_flag_mod, e.res, e.fl, e.fm);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: cycle %0d, expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [63:0] pats [3];
    pats[0] = 64'hF0E1_D2C3_B4A5_9687;
    pats[1] = 64'h0123_4567_89AB_CDEF;
    pats[2] = 64'h4000_0000_8000_C0C1;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_size = '0;
    in_operand = '0; in_count = '0; in_flags = '0;
    repeat (3) @(negedge clk);
    check_bit(out_valid, 1'b0, "R11");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R11");

    // Directed cases
    send(2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFF7, 8'd2, 6'd0, "R4");   // -9 >> 2
    idle();
    check_bit(out_valid, 1'b1, "R11");
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R11");
    send(2'd0, 2'd0, 64'h0000_0000_0000_0041, 8'h21, 6'd0, "R1");  // folds to 1
    send(2'd2, 2'd3, 64'h8000_0000_0000_0001, 8'h7F, 6'd0, "R1");  // folds to 63
    send(2'd2, 2'd1, 64'h0000_0000_0000_FFFF, 8'd16, 6'd0, "R5");
    send(2'd0, 2'd0, 64'h0000_0000_0000_0001, 8'd8, 6'd0, "R5");
    send(2'd3, 2'd0, 64'h0000_0000_0000_0080, 8'd20, 6'd0, "R5");
    send(2'd1, 2'd2, 64'h0000_0000_E000_0000, 8'd3, 6'h20, "R8");
    send(2'd2, 2'd0, 64'h0000_0000_0000_0080, 8'd7, 6'h3F, "R9");
    send(2'd1, 2'd0, 64'h0000_0000_0000_0081, 8'd8, 6'h00, "R9");
    send(2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd4, 6'd0, "R10");
    send(2'd3, 2'd2, 64'h1234_5678_8000_0000, 8'd1, 6'd0, "R10");
    send(2'd2, 2'd2, 64'h0000_0000_8000_0000, 8'd1, 6'd0, "R7");
    send(2'd0, 2'd3, 64'h4000_0000_0000_0000, 8'd1, 6'd0, "R7");
    send(2'd2, 2'd1, 64'h0000_0000_0000_1234, 8'd0, 6'h2B, "R6");
    send(2'd0, 2'd0, 64'h0000_0000_0000_0001, 8'd0, 6'h15, "R6");

    // Sweep: every op, width and raw count 0..63
    for (int p = 0; p < 3; p++) begin
      for (int op = 0; op < 4; op++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int c = 0; c < 64; c++) begin
            logic [31:0] tag;
            int mc;
            mc = c & ((sz == 3) ? 63 : 31);
            if (mc == 0) tag = "R6";
            else if (mc == 1) tag = "R7";
            else if (op == 3) tag = "R4";
            else if (op == 2) tag = "R3";
            else tag = "R2";
            send(op[1:0], sz[1:0], pats[p], c[7:0], 6'((c * 7 + op) & 63), tag);
          end
        end
      end
    end
    idle();
    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R11: %0d results missing, expected 0", sbq.size());
    end
    finish_run();
  end
endmodule